// File: doc/BRIEF.md
# Serial NRZ-to-Manchester Line Encoder

This block turns a serial NRZ bit stream into a Manchester-coded line signal. It is clocked at twice the bit rate, so each bit occupies two consecutive fast-clock cycles, a first half and a second half. A one-bit phase state machine tracks which half is being sent. The data bit is captured at the end of the first half, and the line level for each half is derived from it: a 1 is sent as high-then-low and a 0 as low-then-high. This gives a transition in the middle of every bit.

Two output variants sit behind the `MOORE` parameter. With `MOORE = 0` the first-half level is taken straight from the input pin, which adds no delay. If the input edge and the clock edge are skewed, however, the line can show a brief false pulse. With `MOORE = 1` the level is registered, so the line only changes on a clock edge, and the whole waveform moves one fast cycle later. The sender must hold each NRZ bit for two fast cycles. Bit boundaries start at the first cycle after synchronous reset is released.

Top module: `manch_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle is the first half of a bit. In Mealy mode `manOut` is low in every cycle in which `rst` is high. In Moore mode `manOut` is low in the cycle after a reset edge, including the first cycle after release.
- R2: A data bit of 0 is sent as low in its first half and high in its second half.
- R3: A data bit of 1 is sent as high in its first half and low in its second half.
- R4: In Mealy mode, during a first half, `manOut` equals `nrzIn` in the same cycle, with no register between them.
- R5: In Mealy mode, during a second half, `manOut` is the complement of `nrzIn` as sampled at the edge that ended the first half. Changes of `nrzIn` during the second half have no effect on the line.
- R6: In Moore mode, the level in each cycle equals the Mealy-mode level of the previous cycle. The waveform is the same Manchester sequence, delayed by exactly one fast cycle.
- R7: In Moore mode, `manOut` changes only at rising clock edges. Toggling `nrzIn` between edges does not move the line.
- R8: After reset the half-bit phase alternates on every clock edge. The first cycle after release is a first half, so bit k occupies cycles 2k and 2k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| nrzIn | input | 1 | NRZ data, held stable for two fast cycles per bit |
| manOut | output | 1 | Manchester-coded line level |

## Verification
If the phase register slipped, the line would lose its mid-bit transition. A 0 followed by a 1 would then show as a flat level, and a wrong phase would appear at the port within one bit time, no more than two cycles. A captured bit that was stale or never loaded appears in the very next second half as a level that fails to invert. In Moore mode, a missing or doubled output register shows up as a one-cycle misalignment against the delayed reference from the first data cycle after reset.

// File: rtl/manch_pkg.sv
`timescale 1ns/1ps
package manch_pkg;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } halfPhase_e;

  typedef struct packed {
    logic clearAll;    // synchronous clear of the datapath
    logic captureBit;  // end of first half: latch the data bit
    logic secondHalf;  // current cycle is the second half of a bit
  } ctrlStrobes_t;

endpackage

// File: rtl/manch_ctrl.sv
`timescale 1ns/1ps
module manch_ctrl
  import manch_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  output ctrlStrobes_t strb
);

  halfPhase_e phaseQ;

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= PH_FIRST;
    else     phaseQ <= (phaseQ == PH_FIRST) ? PH_SECOND : PH_FIRST;
  end

  always_comb begin
    strb.clearAll   = rst;
    strb.secondHalf = (phaseQ == PH_SECOND);
    strb.captureBit = !rst && (phaseQ == PH_FIRST);
  end

endmodule

// File: rtl/manch_datapath.sv
`timescale 1ns/1ps
module manch_datapath
  import manch_pkg::*;
#(
  parameter bit MOORE = 1'b1
) (
  input  logic         clk,
  input  ctrlStrobes_t strb,
  input  logic         nrzIn,
  output logic         lineOut
);

  logic heldBit;
  logic mealyLvl;

  always_ff @(posedge clk) begin
    if (strb.clearAll)        heldBit <= 1'b0;
    else if (strb.captureBit) heldBit <= nrzIn;
  end

  // first half passes the data bit, second half sends its complement
  always_comb begin
    if (strb.clearAll)        mealyLvl = 1'b0;
    else if (strb.secondHalf) mealyLvl = ~heldBit;
    else                      mealyLvl = nrzIn;
  end

  generate
    if (MOORE) begin : g_moore
      logic outReg;
      always_ff @(posedge clk) begin
        outReg <= mealyLvl;
      end
      assign lineOut = outReg;
    end else begin : g_mealy
      assign lineOut = mealyLvl;
    end
  endgenerate

endmodule

// File: rtl/manch_encoder.sv
`timescale 1ns/1ps
module manch_encoder
  import manch_pkg::*;
#(
  parameter bit MOORE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic nrzIn,
  output logic manOut
);

  ctrlStrobes_t strb;
  logic         inSecondHalf;

  manch_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .strb (strb)
  );

  manch_datapath #(.MOORE(MOORE)) u_dp (
    .clk     (clk),
    .strb    (strb),
    .nrzIn   (nrzIn),
    .lineOut (manOut)
  );

  assign inSecondHalf = strb.secondHalf;

endmodule

// File: rtl/manch_encoder_chk.sv
`timescale 1ns/1ps
module manch_encoder_chk #(
  parameter bit MOORE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic nrzIn,
  input logic manOut,
  input logic secondHalf
);

  // R1: a reset edge leaves the machine at a bit start
  p_bit_start_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !secondHalf);

  // R8: phase flips on every edge outside reset
  p_phase_alt_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (secondHalf != $past(secondHalf)));

  generate
    if (MOORE) begin : g_moore_chk
      // R6: first-half level appears one cycle late
      p_moore_first_r6: assert property (@(posedge clk) disable iff (rst)
        secondHalf |-> (manOut == $past(nrzIn)));
      // R6: second-half level appears one cycle late
      p_moore_second_r6: assert property (@(posedge clk) disable iff (rst)
        (!secondHalf && !$past(rst)) |-> (manOut == !$past(nrzIn, 2)));
    end else begin : g_mealy_chk
      // R4: first half follows the input directly
      p_first_follow_r4: assert property (@(posedge clk) disable iff (rst)
        !secondHalf |-> (manOut == nrzIn));
      // R5: second half is the complement of the captured bit
      p_second_hold_r5: assert property (@(posedge clk) disable iff (rst)
        secondHalf |-> (manOut == !$past(nrzIn)));
    end
  endgenerate

endmodule

bind manch_encoder manch_encoder_chk #(.MOORE(MOORE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .nrzIn      (nrzIn),
  .manOut     (manOut),
  .secondHalf (inSecondHalf)
);

// File: tb/sim_manch_encoder.sv
`timescale 1ns/1ps
module sim_manch_encoder;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic nrz = 1'b0;
  logic outMoore;
  logic outMealy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic prevMealy = 1'b0;
  bit finished = 1'b0;

  manch_encoder #(.MOORE(1'b1)) u0 (
    .clk(clk), .rst(rst), .nrzIn(nrz), .manOut(outMoore)
  );

  manch_encoder #(.MOORE(1'b0)) u1 (
    .clk(clk), .rst(rst), .nrzIn(nrz), .manOut(outMealy)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // one fast cycle: drive rst/nrz after the edge, check at the falling edge
  task automatic cycle(input logic rstV, input logic d, input logic bitV,
                       input bit flip, input string req);
    logic mealyExp;
    logic mooreExp;
    @(posedge clk);
    #1 rst = rstV; nrz = d;
    @(negedge clk);
    mealyExp = rstV ? 1'b0 : (bitV ^ cyc[0]);
    mooreExp = prevMealy;
    chk(req, outMealy, mealyExp);
    chk(rstV ? "R1" : "R6", outMoore, mooreExp);
    if (flip) begin
      #0.5 nrz = ~d;
      #0.5 chk("R4", outMealy, ~d);
      chk("R7", outMoore, mooreExp);
      #0.5 nrz = d;
    end
    prevMealy = mealyExp;
    cyc = rstV ? 0 : cyc + 1;
  endtask

  // mode 0 normal, 1 input disturbed in second half, 2 toggle inside first half
  task automatic sendBit(input logic b, input int mode);
    string tag;
    tag = b ? "R3" : "R2";
    cycle(1'b0, b, b, (mode == 2), tag);
    if (mode == 1) cycle(1'b0, ~b, b, 1'b0, "R5");
    else           cycle(1'b0, b, b, 1'b0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset with input high, Mealy line must stay low
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 1'b0, 1'b0, "R1");
    // R8: fixed patterns aligned to the first cycle after release
    for (int i = 0; i < 4; i++) sendBit(1'b0, 0);
    for (int i = 0; i < 4; i++) sendBit(1'b1, 0);
    for (int i = 0; i < 8; i++) sendBit(1'(i % 2), 0);
    // random stream
    for (int i = 0; i < 300; i++) sendBit(1'($urandom % 2), 0);
    // R5: disturbed second halves
    for (int i = 0; i < 20; i++) sendBit(1'($urandom % 2), 1);
    // R4 / R7: mid-cycle toggles in first halves
    for (int i = 0; i < 20; i++) sendBit(1'($urandom % 2), 2);
    // R1: reset in the middle of a bit, then realignment (R8)
    cycle(1'b0, 1'b1, 1'b1, 1'b0, "R3");
    cycle(1'b1, 1'b1, 1'b0, 1'b0, "R1");
    cycle(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 50; i++) sendBit(1'($urandom % 2), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule